// File: doc/BRIEF.md
# Half-Group Word Access Coalescer

This block sits between a group of sixteen execution lanes and an off-chip memory port. Each lane has an active flag and a 32-bit byte address that points at one aligned 32-bit word. The block sorts the active lanes by the 128-byte aligned segment they touch. It then sends one memory command per distinct segment. Each command carries a 32-bit word-enable mask and, for stores, the merged store data for the whole segment.

A group whose active lanes all fall inside one segment costs a single command, wherever inside the segment the lanes point. Lanes do not have to be in linear order. Lanes that are not active never add a command.

On loads, the block copies each returned segment word into every lane that asked for it. It raises one response when the last command of the group has been answered, and it reports how many commands the group used. Both sides use a valid/ready handshake. The block takes no new group until the current one has been fully answered and handed back.

Top module: `hw_coalescer`

## Requirements
- R1: When every active lane addresses a word in the same 128-byte aligned segment, exactly one memory command is issued for the group.
- R2: A single-segment group costs one command whatever word offset inside the segment the lanes start at.
- R3: Inactive lanes add no command, no mask bit and no data, whatever their address. Their read data in the response is zero.
- R4: When the active lanes span several segments, one command is issued per distinct segment (segment number = address bits 31:7), in strictly ascending segment order.
- R5: In each command, `mem_mask` bit w (w = address bits 6:2) is set if and only if some active lane served by that command addresses word w.
- R6: On a load, each active lane receives word w of its own segment's response, taken from `mem_rsp_rdata` bits w*32+31 : w*32. Several lanes addressing one word all receive it.
- R7: On a store, `mem_write` is 1, and word w of `mem_wdata` holds the store data of the highest-numbered served lane addressing word w. Lane read data is zero in the response to a store.
- R8: `rsp_valid` rises only after every command of the group has been answered. It then stays high, with stable data and count, until `rsp_ready` is seen.
- R9: `req_ready` is high only when no group is in progress, so no group is accepted while commands are outstanding or a response is pending.
- R10: A group with no active lane issues no command and raises `rsp_valid` in the cycle after it is accepted, with a count of zero.
- R11: While `rsp_valid` is high, `dbg_txn_count` equals the number of memory commands issued for that group.
- R12: Once `mem_valid` is raised it stays high, with unchanged segment and mask, until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lane group offered |
| req_ready | output | 1 | Block idle, group can be taken |
| req_write | input | 1 | 1 = store group, 0 = load group |
| req_active | input | 16 | Per-lane active flags |
| req_addr | input | 512 | Lane byte addresses, lane i at bits i*32+31 : i*32 |
| req_wdata | input | 512 | Lane store data, lane i at bits i*32+31 : i*32 |
| mem_valid | output | 1 | Memory command valid |
| mem_ready | input | 1 | Memory command accepted |
| mem_write | output | 1 | Command is a store |
| mem_seg | output | 25 | Segment number (address bits 31:7) |
| mem_mask | output | 32 | Word-enable mask within the segment |
| mem_wdata | output | 1024 | Merged store data, word w at bits w*32+31 : w*32 |
| mem_rsp_valid | input | 1 | Memory answer for the last command |
| mem_rsp_ready | output | 1 | Block waits for an answer |
| mem_rsp_rdata | input | 1024 | Segment load data, word w at bits w*32+31 : w*32 |
| rsp_valid | output | 1 | Group finished |
| rsp_ready | input | 1 | Group result taken |
| rsp_rdata | output | 512 | Per-lane load data |
| dbg_txn_count | output | 5 | Commands issued for the current group |

## Verification
The properties assume the memory side answers each accepted command exactly once. They also assume it raises `mem_rsp_valid` only while `mem_rsp_ready` is high, and that the lane side holds `req_valid` until it is taken. The bench's memory model keeps to this: it captures one command, waits a random 0 to 2 cycles, and returns a single answer built from the segment number and word index. It never answers without an outstanding command. The model also stalls commands at random to exercise command holding. It keeps `rsp_ready` low for random stretches to exercise response holding, and it offers each new group only while the block is idle.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int HWC_LANES     = 16;
  localparam int HWC_ADDR_W    = 32;
  localparam int HWC_DATA_W    = 32;
  localparam int HWC_SEG_BYTES = 128;

  typedef enum logic [1:0] {
    HWC_IDLE  = 2'd0,
    HWC_ISSUE = 2'd1,
    HWC_WAIT  = 2'd2,
    HWC_DONE  = 2'd3
  } hwc_state_e;
endpackage

// File: rtl/hwc_seg_picker.sv
// Finds the lowest segment among still-pending lanes and the lanes it serves.
module hwc_seg_picker #(
  parameter int LANES     = 16,
  parameter int ADDR_W    = 32,
  parameter int SEG_LSB   = 7
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [ADDR_W-SEG_LSB-1:0] min_seg,
  output logic [LANES-1:0]        served
);
  localparam int SEG_W = ADDR_W - SEG_LSB;

  function automatic logic [SEG_W-1:0] seg_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SEG_LSB];
  endfunction

  logic [SEG_W-1:0] best;
  logic             found;

  always_comb begin
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (pending[i] && (!found || seg_of(addr_flat[i*ADDR_W +: ADDR_W]) < best)) begin
        best  = seg_of(addr_flat[i*ADDR_W +: ADDR_W]);
        found = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_served
    assign served[g] = pending[g] && (seg_of(addr_flat[g*ADDR_W +: ADDR_W]) == best);
  end

  assign min_seg = best;
endmodule

// File: rtl/hwc_mask_builder.sv
// Builds the word mask and merged store data for the served lanes.
module hwc_mask_builder #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SEG_LSB  = 7,
  parameter int WORD_LSB = 2
) (
  input  logic [LANES-1:0]        served,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES*DATA_W-1:0] wdata_flat,
  output logic [(1<<(SEG_LSB-WORD_LSB))-1:0]        word_mask,
  output logic [(1<<(SEG_LSB-WORD_LSB))*DATA_W-1:0] seg_wdata
);
  localparam int WIDX_W = SEG_LSB - WORD_LSB;

  function automatic logic [WIDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[SEG_LSB-1:WORD_LSB];
  endfunction

  always_comb begin
    word_mask = '0;
    seg_wdata = '0;
    // Ascending lane order: a later (higher) lane overwrites an earlier one.
    for (int i = 0; i < LANES; i++) begin
      if (served[i]) begin
        word_mask[word_of(addr_flat[i*ADDR_W +: ADDR_W])] = 1'b1;
        seg_wdata[int'(word_of(addr_flat[i*ADDR_W +: ADDR_W]))*DATA_W +: DATA_W] =
          wdata_flat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/hwc_read_scatter.sv
// Routes words of a returned segment to the lanes that asked for them.
module hwc_read_scatter #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int SEG_LSB  = 7,
  parameter int WORD_LSB = 2
) (
  input  logic [LANES-1:0]        lanes,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [(1<<(SEG_LSB-WORD_LSB))*DATA_W-1:0] seg_rdata,
  input  logic [LANES*DATA_W-1:0] cur_rdata,
  output logic [LANES*DATA_W-1:0] nxt_rdata
);
  localparam int WIDX_W = SEG_LSB - WORD_LSB;

  function automatic logic [WIDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[SEG_LSB-1:WORD_LSB];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDX_W-1:0] widx;
    assign widx = word_of(addr_flat[g*ADDR_W +: ADDR_W]);
    assign nxt_rdata[g*DATA_W +: DATA_W] = lanes[g] ? seg_rdata[int'(widx)*DATA_W +: DATA_W]
                                                    : cur_rdata[g*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import hwc_pkg::*;
#(
  parameter int LANES     = HWC_LANES,
  parameter int ADDR_W    = HWC_ADDR_W,
  parameter int DATA_W    = HWC_DATA_W,
  parameter int SEG_BYTES = HWC_SEG_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [LANES-1:0]             req_active,
  input  logic [LANES*ADDR_W-1:0]      req_addr,
  input  logic [LANES*DATA_W-1:0]      req_wdata,
  output logic                         mem_valid,
  input  logic                         mem_ready,
  output logic                         mem_write,
  output logic [ADDR_W-$clog2(SEG_BYTES)-1:0]           mem_seg,
  output logic [SEG_BYTES/(DATA_W/8)-1:0]               mem_mask,
  output logic [SEG_BYTES*8-1:0]                        mem_wdata,
  input  logic                         mem_rsp_valid,
  output logic                         mem_rsp_ready,
  input  logic [SEG_BYTES*8-1:0]       mem_rsp_rdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [LANES*DATA_W-1:0]      rsp_rdata,
  output logic [$clog2(LANES+1)-1:0]   dbg_txn_count
);
  localparam int SEG_LSB  = $clog2(SEG_BYTES);
  localparam int WORD_LSB = $clog2(DATA_W/8);
  localparam int SEG_W    = ADDR_W - SEG_LSB;
  localparam int CNT_W    = $clog2(LANES+1);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  hwc_state_e                st_q;
  logic                      write_q;
  logic [LANES*ADDR_W-1:0]   addr_q;
  logic [LANES*DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]          pending_q;
  logic [LANES-1:0]          cur_lanes_q;
  logic [LANES*DATA_W-1:0]   rdata_q;
  logic [CNT_W-1:0]          cnt_q;

  // Named internal events
  logic                      req_fire;
  logic                      issue_fire;
  logic                      answer_fire;
  logic                      group_empty;
  logic                      last_answer;
  logic [LANES-1:0]          served;
  logic [SEG_W-1:0]          pick_seg;
  logic [LANES*DATA_W-1:0]   scatter_rdata;

  assign req_ready     = (st_q == HWC_IDLE);
  assign mem_valid     = (st_q == HWC_ISSUE);
  assign mem_rsp_ready = (st_q == HWC_WAIT);
  assign rsp_valid     = (st_q == HWC_DONE);
  assign req_fire      = req_valid && req_ready;
  assign issue_fire    = mem_valid && mem_ready;
  assign answer_fire   = mem_rsp_valid && mem_rsp_ready;
  assign group_empty   = (req_active == '0);
  assign last_answer   = answer_fire && (pending_q == '0);

  hwc_seg_picker #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_LSB(SEG_LSB)
  ) u_picker (
    .pending   (pending_q),
    .addr_flat (addr_q),
    .min_seg   (pick_seg),
    .served    (served)
  );

  hwc_mask_builder #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEG_LSB(SEG_LSB), .WORD_LSB(WORD_LSB)
  ) u_builder (
    .served     (served),
    .addr_flat  (addr_q),
    .wdata_flat (wdata_q),
    .word_mask  (mem_mask),
    .seg_wdata  (mem_wdata)
  );

  hwc_read_scatter #(
    .LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEG_LSB(SEG_LSB), .WORD_LSB(WORD_LSB)
  ) u_scatter (
    .lanes     (cur_lanes_q),
    .addr_flat (addr_q),
    .seg_rdata (mem_rsp_rdata),
    .cur_rdata (rdata_q),
    .nxt_rdata (scatter_rdata)
  );

  assign mem_seg       = pick_seg;
  assign mem_write     = write_q;
  assign rsp_rdata     = rdata_q;
  assign dbg_txn_count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= HWC_IDLE;
      write_q     <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      pending_q   <= '0;
      cur_lanes_q <= '0;
      rdata_q     <= '0;
      cnt_q       <= '0;
    end else begin
      unique case (st_q)
        HWC_IDLE: begin
          if (req_fire) begin
            write_q   <= req_write;
            addr_q    <= req_addr;
            wdata_q   <= req_wdata;
            pending_q <= req_active;
            rdata_q   <= '0;
            cnt_q     <= '0;
            st_q      <= group_empty ? HWC_DONE : HWC_ISSUE;
          end
        end
        HWC_ISSUE: begin
          if (issue_fire) begin
            pending_q   <= pending_q & ~served;
            cur_lanes_q <= served;
            cnt_q       <= cnt_q + CNT_ONE;
            st_q        <= HWC_WAIT;
          end
        end
        HWC_WAIT: begin
          if (answer_fire) begin
            if (!write_q) rdata_q <= scatter_rdata;
            st_q <= last_answer ? HWC_DONE : HWC_ISSUE;
          end
        end
        HWC_DONE: begin
          if (rsp_ready) st_q <= HWC_IDLE;
        end
        default: st_q <= HWC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker #(
  parameter int LANES  = 16,
  parameter int SEG_W  = 25,
  parameter int MASK_W = 32,
  parameter int RD_W   = 512,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [SEG_W-1:0]  mem_seg,
  input logic [MASK_W-1:0] mem_mask,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [RD_W-1:0]   rsp_rdata,
  input logic [CNT_W-1:0]  dbg_txn_count,
  input logic              req_fire,
  input logic              issue_fire
);
  logic             seen_q;
  logic [SEG_W-1:0] last_seg_q;
  logic [CNT_W-1:0] n_issued_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q     <= 1'b0;
      last_seg_q <= '0;
      n_issued_q <= '0;
    end else if (req_fire) begin
      seen_q     <= 1'b0;
      n_issued_q <= '0;
    end else if (issue_fire) begin
      seen_q     <= 1'b1;
      last_seg_q <= mem_seg;
      n_issued_q <= n_issued_q + 1'b1;
    end
  end

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || rsp_valid) |-> !req_ready);

  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_seg) && $stable(mem_mask)));

  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_mask != '0));

  p_ascending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && seen_q) |-> (mem_seg > last_seg_q));

  p_empty_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_active == '0)) |=> (rsp_valid && dbg_txn_count == '0));

  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(dbg_txn_count)));

  p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (dbg_txn_count == n_issued_q));
endmodule

bind hw_coalescer hwc_checker #(
  .LANES  (LANES),
  .SEG_W  (ADDR_W - $clog2(SEG_BYTES)),
  .MASK_W (SEG_BYTES/(DATA_W/8)),
  .RD_W   (LANES*DATA_W),
  .CNT_W  ($clog2(LANES+1))
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_active    (req_active),
  .mem_valid     (mem_valid),
  .mem_ready     (mem_ready),
  .mem_seg       (mem_seg),
  .mem_mask      (mem_mask),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .dbg_txn_count (dbg_txn_count),
  .req_fire      (req_fire),
  .issue_fire    (issue_fire)
);

// File: tb/hw_coalescer_test.sv
`timescale 1ns/1ps
module hw_coalescer_test;
  localparam int NL = 16;
  localparam int SW = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic              req_ready;
  logic [NL-1:0]     req_active = '0;
  logic [NL*32-1:0]  req_addr = '0, req_wdata = '0;
  logic              mem_valid, mem_write, mem_rsp_ready;
  logic              mem_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [SW-1:0]     mem_seg;
  logic [31:0]       mem_mask;
  logic [1023:0]     mem_wdata;
  logic [1023:0]     mem_rsp_rdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b0;
  logic [NL*32-1:0]  rsp_rdata;
  logic [4:0]        dbg_txn_count;

  hw_coalescer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_seg(mem_seg), .mem_mask(mem_mask), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_rdata(mem_rsp_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .dbg_txn_count(dbg_txn_count)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] t_addr [NL];
  logic [31:0] t_wd   [NL];

  // Expected command stream, built from the requirements
  logic [SW-1:0] q_seg  [$];
  logic [31:0]   q_mask [$];
  logic [1023:0] q_wd   [$];
  bit            cur_wr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memword(input logic [SW-1:0] s, input logic [4:0] w);
    return {2'b01, s, w};
  endfunction

  function automatic logic [1023:0] seg_fill(input logic [SW-1:0] s);
    logic [1023:0] r;
    for (int w = 0; w < 32; w++) r[w*32 +: 32] = memword(s, 5'(w));
    return r;
  endfunction

  // Memory side model: random stall, random answer latency
  int ph = 0;
  int lat = 0;
  bit stalled = 0;
  logic [SW-1:0] cap_seg, stall_seg;
  logic [31:0]   stall_mask;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        ph = 0; mem_ready = 1'b0; mem_rsp_valid = 1'b0; stalled = 0;
      end else begin
        case (ph)
          0: begin
            if (mem_valid) begin
              if (stalled)
                chk(mem_seg == stall_seg && mem_mask == stall_mask, "R12 command held",
                    {7'd0, mem_seg, mem_mask}, {7'd0, stall_seg, stall_mask});
              if ($urandom % 3 == 0) begin
                stalled = 1; stall_seg = mem_seg; stall_mask = mem_mask; mem_ready = 1'b0;
              end else begin
                stalled = 0;
                mem_ready = 1'b1;
                if (q_seg.size() == 0) begin
                  chk(0, "R4 unexpected command", 64'(mem_seg), 0);
                end else begin
                  logic [SW-1:0] es;
                  logic [31:0]   em;
                  logic [1023:0] ew;
                  es = q_seg.pop_front(); em = q_mask.pop_front(); ew = q_wd.pop_front();
                  chk(mem_seg == es, "R4 segment order", 64'(mem_seg), 64'(es));
                  chk(mem_mask == em, "R5 word mask", 64'(mem_mask), 64'(em));
                  chk(mem_write == cur_wr, "R7 write flag", 64'(mem_write), 64'(cur_wr));
                  if (cur_wr)
                    for (int w = 0; w < 32; w++)
                      if (em[w])
                        chk(mem_wdata[w*32 +: 32] == ew[w*32 +: 32], "R7 merged store word",
                            64'(mem_wdata[w*32 +: 32]), 64'(ew[w*32 +: 32]));
                end
                cap_seg = mem_seg;
                lat = $urandom % 3;
                ph = 1;
              end
            end
          end
          1: begin
            mem_ready = 1'b0;
            if (lat == 0) begin
              mem_rsp_valid = 1'b1;
              mem_rsp_rdata = seg_fill(cap_seg);
              ph = 2;
            end else lat--;
          end
          default: begin
            mem_rsp_valid = 1'b0;
            ph = 0;
          end
        endcase
      end
    end
  end

  // Build expectations and run one group through the block
  task automatic run_group(input bit wr, input logic [NL-1:0] act, input string tag);
    logic [SW-1:0] last;
    bit            have;
    int            nseg;
    int            cyc;
    logic [31:0]   exp_rd [NL];
    nseg = 0; have = 0; last = '0;
    cur_wr = wr;
    forever begin
      logic [SW-1:0] best;
      bit found;
      logic [31:0] m;
      logic [1023:0] wd;
      found = 0; best = '0;
      for (int i = 0; i < NL; i++)
        if (act[i] && (!have || t_addr[i][31:7] > last) && (!found || t_addr[i][31:7] < best)) begin
          best = t_addr[i][31:7]; found = 1;
        end
      if (!found) break;
      m = '0; wd = '0;
      for (int i = 0; i < NL; i++)
        if (act[i] && t_addr[i][31:7] == best) begin
          m[t_addr[i][6:2]] = 1'b1;
          wd[int'(t_addr[i][6:2])*32 +: 32] = t_wd[i];
        end
      q_seg.push_back(best); q_mask.push_back(m); q_wd.push_back(wd);
      last = best; have = 1; nseg++;
    end
    for (int i = 0; i < NL; i++)
      exp_rd[i] = (wr || !act[i]) ? 32'd0 : memword(t_addr[i][31:7], t_addr[i][6:2]);

    @(negedge clk);
    chk(req_ready == 1'b1, {"R9 idle ready ", tag}, 64'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_active = act;
    for (int i = 0; i < NL; i++) begin
      req_addr[i*32 +: 32] = t_addr[i];
      req_wdata[i*32 +: 32] = t_wd[i];
    end
    @(negedge clk);
    req_valid = 1'b0; req_active = ~act; req_addr = ~req_addr; req_wdata = ~req_wdata;
    if (act == '0) chk(rsp_valid == 1'b1, {"R10 immediate done ", tag}, 64'(rsp_valid), 1);
    cyc = 0;
    while (!rsp_valid && cyc < 3000) begin
      chk(req_ready == 1'b0, {"R9 busy not ready ", tag}, 64'(req_ready), 0);
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid == 1'b1, {"R8 response arrives ", tag}, 64'(rsp_valid), 1);
    chk(q_seg.size() == 0, {"R8 all commands done before response ", tag}, 64'(q_seg.size()), 0);
    chk(dbg_txn_count == 5'(nseg), {"R11 command count ", tag}, 64'(dbg_txn_count), 64'(nseg));
    for (int i = 0; i < NL; i++)
      chk(rsp_rdata[i*32 +: 32] == exp_rd[i], {"R6 lane data ", tag},
          64'(rsp_rdata[i*32 +: 32]), 64'(exp_rd[i]));
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid && dbg_txn_count == 5'(nseg) && rsp_rdata[31:0] == exp_rd[0],
          {"R8 response held ", tag}, 64'(rsp_valid), 1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, {"R8 response released ", tag}, 64'(rsp_valid), 0);
    q_seg.delete(); q_mask.delete(); q_wd.delete();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog R8: actual=%0d expected<150000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin t_addr[i] = '0; t_wd[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 reset ready", 64'(req_ready), 1);
    chk(mem_valid == 1'b0, "R12 reset no command", 64'(mem_valid), 0);
    chk(rsp_valid == 1'b0, "R8 reset no response", 64'(rsp_valid), 0);
    chk(dbg_txn_count == 0, "R11 reset count", 64'(dbg_txn_count), 0);

    // R1: linear group at segment base
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h1000 + 32'(4*i);
    run_group(0, 16'hFFFF, "R1 linear base");

    // R2: linear group at word offsets 16 and 8
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h2040 + 32'(4*i);
    run_group(0, 16'hFFFF, "R2 offset 16");
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h3020 + 32'(4*i);
    run_group(0, 16'hFFFF, "R2 offset 8");

    // R4: straddles two segments
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h4060 + 32'(4*i);
    run_group(0, 16'hFFFF, "R4 straddle");

    // R3: inactive lanes point elsewhere
    for (int i = 0; i < NL; i++) t_addr[i] = (i % 2 == 0) ? 32'h1000 + 32'(4*i) : 32'h9000 + 32'(512*i);
    run_group(0, 16'h5555, "R3 inactive elsewhere");
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h1000 + 32'(4*i);
    run_group(0, 16'hA5A5, "R3 sparse active");

    // R4: every lane its own segment, lanes in descending segment order
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h20000 + 32'((15-i)*128 + 4*i);
    run_group(0, 16'hFFFF, "R4 descending lanes");

    // R6: all lanes same word
    for (int i = 0; i < NL; i++) t_addr[i] = 32'h5554;
    run_group(0, 16'hFFFF, "R6 broadcast");

    // R7: linear store, then store with duplicated words
    for (int i = 0; i < NL; i++) begin t_addr[i] = 32'h6000 + 32'(4*i); t_wd[i] = 32'hC0DE0000 + 32'(i); end
    run_group(1, 16'hFFFF, "R7 linear store");
    for (int i = 0; i < NL; i++) begin t_addr[i] = 32'h7000 + 32'(4*(i%4)); t_wd[i] = 32'hBEEF0000 + 32'(i); end
    run_group(1, 16'hFFFF, "R7 duplicate words");

    // R10: empty groups
    run_group(0, 16'h0000, "R10 empty load");
    run_group(1, 16'h0000, "R10 empty store");

    // Mixed random groups
    for (int k = 0; k < 60; k++) begin
      logic [SW-1:0] base;
      logic [NL-1:0] act;
      base = SW'(32'h100 + ($urandom % 64));
      for (int i = 0; i < NL; i++) begin
        t_addr[i] = {base + SW'($urandom % 3), 5'($urandom % 32), 2'b00};
        t_wd[i]   = $urandom;
      end
      act = NL'($urandom);
      if (k % 10 == 3) act = '1;
      if (k % 17 == 5) act = '0;
      run_group(bit'($urandom % 2), act, "R4 random group");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule